// File: doc/BRIEF.md
# NAND Flash Asynchronous Strobe Controller

This block turns single-transfer requests from a host into strobed cycles on an 8-bit asynchronous NAND flash bus. Each request names the cycle kind (command, address or data), the direction, and for writes the byte to send. The controller raises the command-latch or address-latch line to match the kind. It then pulls the chip enable low and produces a write or read strobe framed by a setup phase and a hold phase. The lengths of these phases come from a single 32-bit timing word, with separate values for reads and writes. After every transfer a turnaround gap keeps the bus quiet before the next one. A select-only request updates the latch lines and drives no strobe, which lets software change the CLE/ALE state without a bus write.

The controller is one state machine with five states. IDLE waits for a request. SETUP holds chip enable low with both strobes high. STROBE drives the active-low write or read strobe. HOLD keeps chip enable low after the strobe. TURN is the quiet gap. The transitions are:
- accept-bus: IDLE to SETUP, on a request.
- accept-select: IDLE to TURN, on a select-only request.
- setup-done: SETUP to STROBE.
- strobe-done: STROBE to HOLD.
- hold-done: HOLD to TURN.
- gap-done: TURN to IDLE.

Each timed state loads a down-counter with its field value and leaves when the count reaches zero. The flash ready/busy pin reaches the host as a synchronised status bit.

Top module: `nand_strobe_ctrl`

## Requirements
- R1: While reset is active, and on leaving reset, the outputs are in their idle state: `nand_ce_n`, `nand_we_n` and `nand_re_n` are high; `nand_cle`, `nand_ale`, `ack` and `nand_dq_oe` are low; `status_ready` is low.
- R2: The timing word uses these fields: write setup in bits [29:26], write strobe in [25:20], write hold in [19:17], read setup in [16:13], read strobe in [12:7], read hold in [6:4], turnaround in [3:2], bus size in [1:0]. Every phase lasts its field value plus one clock cycles. The word is captured when a request is accepted.
- R3: A write keeps `nand_ce_n` low through setup, strobe and hold. `nand_we_n` is low only during the strobe phase, and `nand_re_n` stays high. `nand_dq_oe` is high and `nand_dq_out` equals the request byte for every cycle in which `nand_ce_n` is low.
- R4: A read uses the read fields. `nand_re_n` is low only during the strobe phase, `nand_we_n` stays high, and `nand_dq_oe` stays low.
- R5: Read data is captured from `nand_dq_in` at the rising clock edge that ends the last strobe cycle. It is held on `rd_data` until the next read.
- R6: `req_kind` 2'b01 selects a command cycle (`nand_cle`=1, `nand_ale`=0). 2'b10 selects an address cycle (`nand_ale`=1, `nand_cle`=0). 2'b00 and 2'b11 clear both lines. Both lines are cleared and set again on every accepted request, and they hold their values from then until the next accepted request.
- R7: A request with `req_nobus`=1 updates `nand_cle`/`nand_ale` as in R6 and gives `ack` in the cycle after acceptance. It drives no chip enable and no strobe.
- R8: `ack` is a one-cycle pulse. For a bus transfer it appears in the first cycle after the last hold cycle.
- R9: If a request is still asserted when `ack` occurs, `nand_ce_n` stays high for exactly turnaround plus two cycles between the two transfers.
- R10: `status_ready` follows `nand_rb_n` (1 = ready) after two rising clock edges.
- R11: The bus-size field has no effect on timing or data: the data bus is always 8 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 32 | Packed timing word (R2) |
| req | input | 1 | Transfer request, held until `ack` |
| req_kind | input | 2 | Cycle kind: 00 data, 01 command, 10 address, 11 data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_nobus | input | 1 | 1 = update latch lines only |
| req_wdata | input | 8 | Byte to write |
| ack | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Last byte read |
| status_ready | output | 1 | Synchronised flash ready status |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Data driven to the flash |
| nand_dq_oe | output | 1 | Output enable for `nand_dq_out` |
| nand_dq_in | input | 8 | Data from the flash |
| nand_rb_n | input | 1 | Flash ready/busy pin, 1 = ready |

## Verification
A wrong state register or phase counter shows up at the pins within the transfer that holds it. The low period of a strobe or of the chip enable is then too long or too short by whole cycles, or `ack` arrives a cycle away from the end of the hold phase. A wrong direction or kind latch is visible in the first cycle of chip enable, as the wrong strobe or latch line, or as an output enable that does not match the direction. A capture edge that is off by one returns the decoy byte that the bench drives in every strobe cycle except the last. The bench sweeps every setup, strobe and hold value in a small range for both directions and compares each measured width with the field value plus one.

// File: rtl/nsc_pkg.sv
package nsc_pkg;
    localparam int CFG_W = 32;
    localparam int WS_LSB = 26;
    localparam int WS_W   = 4;
    localparam int WT_LSB = 20;
    localparam int WT_W   = 6;
    localparam int WH_LSB = 17;
    localparam int WH_W   = 3;
    localparam int RS_LSB = 13;
    localparam int RS_W   = 4;
    localparam int RT_LSB = 7;
    localparam int RT_W   = 6;
    localparam int RH_LSB = 4;
    localparam int RH_W   = 3;
    localparam int TA_LSB = 2;
    localparam int TA_W   = 2;
    localparam int CNT_W  = (WT_W > RT_W) ? WT_W : RT_W;

    typedef enum logic [1:0] {
        KIND_DATA = 2'b00,
        KIND_CMD  = 2'b01,
        KIND_ADDR = 2'b10,
        KIND_RSVD = 2'b11
    } kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_TURN
    } state_e;

    typedef struct packed {
        logic [CNT_W-1:0] setup;
        logic [CNT_W-1:0] strobe;
        logic [CNT_W-1:0] hold;
        logic [CNT_W-1:0] turn;
    } phase_t;
endpackage

// File: rtl/nsc_cfg_decode.sv
module nsc_cfg_decode
    import nsc_pkg::*;
(
    input  logic [CFG_W-1:0] cfg,
    input  logic             is_write,
    output phase_t           ph
);
    logic unused_cfg_bits;
    assign unused_cfg_bits = ^{cfg[31:30], cfg[1:0]};

    always_comb begin
        if (is_write) begin
            ph.setup  = CNT_W'(cfg[WS_LSB +: WS_W]);
            ph.strobe = CNT_W'(cfg[WT_LSB +: WT_W]);
            ph.hold   = CNT_W'(cfg[WH_LSB +: WH_W]);
        end else begin
            ph.setup  = CNT_W'(cfg[RS_LSB +: RS_W]);
            ph.strobe = CNT_W'(cfg[RT_LSB +: RT_W]);
            ph.hold   = CNT_W'(cfg[RH_LSB +: RH_W]);
        end
        ph.turn = CNT_W'(cfg[TA_LSB +: TA_W]);
    end
endmodule

// File: rtl/nsc_phase_timer.sv
module nsc_phase_timer #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/nsc_sync.sv
module nsc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q[0] <= 1'b0;
                else        pipe_q[0] <= d;
            end
        end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q[i] <= 1'b0;
                else        pipe_q[i] <= pipe_q[i-1];
            end
        end
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/nand_strobe_ctrl.sv
module nand_strobe_ctrl
    import nsc_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_W-1:0]  cfg_word,
    input  logic              req,
    input  logic [1:0]        req_kind,
    input  logic              req_write,
    input  logic              req_nobus,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ack,
    output logic [DATA_W-1:0] rd_data,
    output logic              status_ready,
    output logic              nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic [DATA_W-1:0] nand_dq_out,
    output logic              nand_dq_oe,
    input  logic [DATA_W-1:0] nand_dq_in,
    input  logic              nand_rb_n
);
    state_e            state_q, state_d;
    phase_t            ph;
    logic              last, load;
    logic [CNT_W-1:0]  load_val;
    logic [CFG_W-1:0]  cfg_q, sel_cfg;
    logic              wr_q, sel_wr;
    logic              cle_q, ale_q, ack_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;
    logic              accept;
    logic              ce_act, strobe_act;
    kind_e             kind_in;

    assign kind_in = kind_e'(req_kind);
    assign accept  = (state_q == ST_IDLE) && req;
    assign sel_cfg = (state_q == ST_IDLE) ? cfg_word  : cfg_q;
    assign sel_wr  = (state_q == ST_IDLE) ? req_write : wr_q;

    nsc_cfg_decode u_decode (
        .cfg      (sel_cfg),
        .is_write (sel_wr),
        .ph       (ph)
    );

    nsc_phase_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .last     (last)
    );

    nsc_sync #(.STAGES(SYNC_STAGES)) u_rb_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (nand_rb_n),
        .q     (status_ready)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req) state_d = req_nobus ? ST_TURN : ST_SETUP;
            ST_SETUP:  if (last) state_d = ST_STROBE;
            ST_STROBE: if (last) state_d = ST_HOLD;
            ST_HOLD:   if (last) state_d = ST_TURN;
            ST_TURN:   if (last) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Phase timer reload on every entry to a timed state
    assign load = (state_d != state_q) && (state_d != ST_IDLE);

    always_comb begin
        unique case (state_d)
            ST_SETUP:  load_val = ph.setup;
            ST_STROBE: load_val = ph.strobe;
            ST_HOLD:   load_val = ph.hold;
            ST_TURN:   load_val = ph.turn;
            default:   load_val = '0;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Request capture, latch lines, acknowledge, read capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            wr_q    <= 1'b0;
            wdata_q <= '0;
            cle_q   <= 1'b0;
            ale_q   <= 1'b0;
            ack_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            ack_q <= (state_q == ST_HOLD && last) || (accept && req_nobus);
            if (accept) begin
                cfg_q   <= cfg_word;
                wr_q    <= req_write && !req_nobus;
                wdata_q <= req_wdata;
                cle_q   <= (kind_in == KIND_CMD);
                ale_q   <= (kind_in == KIND_ADDR);
            end
            if (state_q == ST_STROBE && last && !wr_q)
                rdata_q <= nand_dq_in;
        end
    end

    // Output decode
    always_comb begin
        ce_act     = 1'b0;
        strobe_act = 1'b0;
        unique case (state_q)
            ST_SETUP:  ce_act = 1'b1;
            ST_STROBE: begin ce_act = 1'b1; strobe_act = 1'b1; end
            ST_HOLD:   ce_act = 1'b1;
            default:   ;
        endcase
    end

    assign nand_ce_n   = !ce_act;
    assign nand_we_n   = !(strobe_act && wr_q);
    assign nand_re_n   = !(strobe_act && !wr_q);
    assign nand_dq_oe  = ce_act && wr_q;
    assign nand_dq_out = wdata_q;
    assign nand_cle    = cle_q;
    assign nand_ale    = ale_q;
    assign ack         = ack_q;
    assign rd_data     = rdata_q;

    // Checks
    assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n));
    assert_strobe_inside_ce_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n || !nand_re_n) |-> !nand_ce_n);
    assert_oe_only_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        nand_dq_oe |-> (!nand_ce_n && nand_re_n));
    assert_latch_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));
    assert_latch_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_ce_n && !$past(nand_ce_n)) |-> ($stable(nand_cle) && $stable(nand_ale)));
    assert_ack_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
    assert_ack_after_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nand_ce_n) |-> ack);
endmodule

// File: tb/nand_strobe_ctrl_test.sv
module nand_strobe_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_word = '0;
    logic        req = 1'b0;
    logic [1:0]  req_kind = 2'b00;
    logic        req_write = 1'b0;
    logic        req_nobus = 1'b0;
    logic [7:0]  req_wdata = '0;
    logic        ack;
    logic [7:0]  rd_data;
    logic        status_ready;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [7:0]  nand_dq_out;
    logic [7:0]  nand_dq_in = '0;
    logic        nand_rb_n = 1'b1;

    int total = 0;
    int failed = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    nand_strobe_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .req(req), .req_kind(req_kind),
        .req_write(req_write), .req_nobus(req_nobus), .req_wdata(req_wdata), .ack(ack),
        .rd_data(rd_data), .status_ready(status_ready), .nand_ce_n(nand_ce_n),
        .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
        .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
        .nand_dq_in(nand_dq_in), .nand_rb_n(nand_rb_n)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            total++; failed++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_cfg(input int ws, wt, wh, rs, rt, rh, ta, bs);
        logic [31:0] c;
        c = '0;
        c[29:26] = 4'(ws); c[25:20] = 6'(wt); c[19:17] = 3'(wh);
        c[16:13] = 4'(rs); c[12:7]  = 6'(rt); c[6:4]   = 3'(rh);
        c[3:2]   = 2'(ta); c[1:0]   = 2'(bs);
        return c;
    endfunction

    task automatic do_access(input logic [1:0] kind, input bit wr, input logic [7:0] wd,
                             input logic [7:0] rdv, input int es, input int et, input int eh,
                             input bit keep, input int eta);
        int ns = 0, nt = 0, nh = 0, cyc = 0, ack_cyc = -1, ceh_cyc = -1, gap;
        bit bad = 0, seen_ack = 0;
        string rq;
        rq = wr ? "R3" : "R4";
        @(negedge clk);
        req = 1'b1; req_kind = kind; req_write = wr; req_wdata = wd; req_nobus = 1'b0;
        nand_dq_in = ~rdv;
        while (!seen_ack && cyc < 400) begin
            @(negedge clk);
            cyc++;
            if (!nand_ce_n) begin
                if (wr ? !nand_we_n : !nand_re_n) begin
                    nt++;
                    if (!wr) nand_dq_in = (nt == et) ? rdv : ~rdv;
                end else if (nt == 0) ns++;
                else nh++;
                if ((wr ? nand_re_n : nand_we_n) != 1'b1) bad = 1;
                if (nand_dq_oe != wr) bad = 1;
                if (wr && nand_dq_out != wd) bad = 1;
                if (nand_cle != (kind == 2'b01) || nand_ale != (kind == 2'b10)) bad = 1;
            end else if (ceh_cyc < 0 && (ns + nt + nh) > 0) ceh_cyc = cyc;
            if (ack) begin seen_ack = 1; ack_cyc = cyc; end
        end
        check(ns == es, {"R2 setup ", rq}, ns, es);
        check(nt == et, {"R2 strobe ", rq}, nt, et);
        check(nh == eh, {"R2 hold ", rq}, nh, eh);
        check(!bad, {rq, " pin levels during access"}, bad, 0);
        check(ack_cyc == ceh_cyc && ack_cyc > 0, "R8 ack timing", ack_cyc, ceh_cyc);
        check(nand_cle == (kind == 2'b01) && nand_ale == (kind == 2'b10), "R6 latch held",
              {nand_cle, nand_ale}, {kind == 2'b01, kind == 2'b10});
        if (!wr) check(rd_data == rdv, "R5 read capture", rd_data, rdv);
        if (keep) begin
            gap = 1;
            while (gap < 100) begin
                @(negedge clk);
                if (nand_ce_n) gap++; else break;
            end
            check(gap == eta + 2, "R9 turnaround gap", gap, eta + 2);
            req = 1'b0;
            while (!ack && gap < 200) begin @(negedge clk); gap++; end
        end
        req = 1'b0;
    endtask

    task automatic do_select(input logic [1:0] kind, input int eta);
        bit quiet = 1;
        repeat (8) @(negedge clk);
        req = 1'b1; req_nobus = 1'b1; req_kind = kind; req_write = 1'b1;
        @(negedge clk);
        check(ack == 1'b1, "R7 select ack", ack, 1);
        check(nand_cle == (kind == 2'b01) && nand_ale == (kind == 2'b10), "R6 select latch",
              {nand_cle, nand_ale}, {kind == 2'b01, kind == 2'b10});
        req = 1'b0; req_nobus = 1'b0;
        for (int i = 0; i <= eta + 1; i++) begin
            if (!nand_ce_n || !nand_we_n || !nand_re_n) quiet = 0;
            @(negedge clk);
        end
        check(quiet, "R7 no bus cycle", quiet, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale && !ack &&
              !nand_dq_oe && !status_ready, "R1 reset state", 0, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(nand_ce_n && nand_we_n && nand_re_n && !ack && !nand_dq_oe, "R1 after reset", 0, 1);
        @(negedge clk);
        check(status_ready == 1'b1, "R10 ready after sync", status_ready, 1);

        // Write sweep, all kinds in rotation
        for (int s = 0; s < 3; s++)
            for (int t = 0; t < 4; t++)
                for (int h = 0; h < 3; h++) begin
                    cfg_word = mk_cfg(s, t, h, 0, 0, 0, 0, 0);
                    do_access(2'((s + t + h) % 4), 1'b1, 8'(8'h11 * (t + 1) + s + h),
                              8'h00, s + 1, t + 1, h + 1, 1'b0, 0);
                end

        // Read sweep
        for (int s = 0; s < 3; s++)
            for (int t = 0; t < 4; t++)
                for (int h = 0; h < 3; h++) begin
                    cfg_word = mk_cfg(0, 0, 0, s, t, h, 0, 0);
                    do_access(2'((s + h) % 3), 1'b0, 8'h00, 8'(8'h3C + s * 16 + t * 4 + h),
                              s + 1, t + 1, h + 1, 1'b0, 0);
                end

        // Turnaround sweep with back-to-back requests
        for (int a = 0; a < 4; a++) begin
            cfg_word = mk_cfg(1, 3, 1, 1, 5, 1, a, 0);
            do_access(2'b00, 1'b0, 8'h00, 8'(8'hA0 + a), 2, 6, 2, 1'b1, a);
            do_access(2'b01, 1'b1, 8'(8'h50 + a), 8'h00, 2, 4, 2, 1'b1, a);
        end

        // Bus-size field ignored (R11)
        cfg_word = mk_cfg(1, 3, 1, 1, 5, 1, 3, 3);
        do_access(2'b10, 1'b1, 8'hC3, 8'h00, 2, 4, 2, 1'b0, 3);
        do_access(2'b00, 1'b0, 8'h00, 8'h5A, 2, 6, 2, 1'b0, 3);
        check(rd_data == 8'h5A, "R11 data width unchanged", rd_data, 8'h5A);

        // Select-only requests (R7), including the clearing of both lines
        do_select(2'b01, 3);
        do_select(2'b10, 3);
        do_select(2'b00, 3);
        check(!nand_cle && !nand_ale, "R6 both lines cleared", {nand_cle, nand_ale}, 0);

        // Read data held across writes (R5)
        do_access(2'b00, 1'b1, 8'h77, 8'h00, 2, 4, 2, 1'b0, 3);
        check(rd_data == 8'h5A, "R5 rd_data held", rd_data, 8'h5A);

        // Ready/busy synchronisation (R10)
        @(negedge clk); nand_rb_n = 1'b0;
        @(negedge clk);
        check(status_ready == 1'b1, "R10 one edge later", status_ready, 1);
        @(negedge clk);
        check(status_ready == 1'b0, "R10 two edges later", status_ready, 0);
        nand_rb_n = 1'b1;
        repeat (2) @(negedge clk);
        check(status_ready == 1'b1, "R10 ready again", status_ready, 1);

        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule